// File: doc/BRIEF.md
# Cartridge Wait-State Configuration Unit

This block turns one packed 16-bit wait-control word into per-region access latencies for a cartridge bus with three ROM windows, a battery-backed SRAM window and a fixed external work RAM. A master presents a region, an access width (16 or 32 bit), a sequential flag and an instruction-fetch flag. One cycle later the block returns the number of wait cycles for that access. The same lookup also returns the total cost of a burst of N 32-bit transfers to the selected region.

The control word is decoded at the moment it is written, and the derived latencies are stored in a small register table. Every ROM window has its own table for sequential waits. The 32-bit costs are derived from the 16-bit values. A prefetch-enable bit forces instruction fetches from the ROM windows to report zero wait. Data accesses and the non-ROM regions keep their normal values when prefetch is enabled.

Top module: `cart_wait_unit`

## Requirements
- R1: While `rst` is high, both outputs read 0. After reset, ROM windows 0 and 1 report 4 (16-bit non-sequential), 2 (16-bit sequential), 7 (32-bit non-sequential) and 5 (32-bit sequential). ROM window 2 and SRAM report 0 until the first write. External work RAM (region 4) reports 2 for 16-bit and 5 for 32-bit at all times, and writes do not change it.
- R2: For ROM window r (r = 0, 1, 2), the 16-bit non-sequential wait comes from the 2-bit field at bits [3r+3:3r+2]. Codes 0, 1, 2 and 3 give 4, 3, 2 and 8 cycles.
- R3: For ROM window r, bit 3r+4 selects the 16-bit sequential wait. A value of 1 gives 1 cycle. A value of 0 gives 2, 4 or 8 cycles for windows 0, 1 and 2.
- R4: For a ROM window, the 32-bit sequential wait is twice the 16-bit sequential wait plus one. The 32-bit non-sequential wait is the 16-bit non-sequential wait plus the 16-bit sequential wait plus one.
- R5: SRAM (region 3) takes its wait from bits [1:0] through the same 4/3/2/8 table, for both sequential and non-sequential 16-bit access. Its 32-bit wait is twice that value plus one.
- R6: When bit 14 of the last written word is 1, a lookup with the fetch flag set on region 0, 1 or 2 reports 0 wait. Data lookups and fetches to other regions are unchanged. When bit 14 is 0, fetches report the data values.
- R7: `burst_cycles` equals (1 + 32-bit non-sequential wait) + (N − 1) × (1 + 32-bit sequential wait) for the selected region, where N is `burst_len`. N = 0 gives 0. The fetch override does not apply to bursts.
- R8: Outputs are registered and reflect the lookup inputs present at the previous rising edge. A word written at one edge governs a lookup presented in the very next cycle.
- R9: Region codes 5 to 7 report 0 wait and a burst cost of N. Bits 11, 12, 13 and 15 of the control word have no effect on any latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_data | input | CFG_W (16) | Control word |
| lk_region | input | 3 | Region: 0–2 ROM windows, 3 SRAM, 4 work RAM, 5–7 unmapped |
| lk_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| lk_seq | input | 1 | 1 = sequential access |
| lk_fetch | input | 1 | 1 = instruction fetch |
| burst_len | input | BURST_W (8) | Number of 32-bit transfers in a burst |
| wait_cycles | output | 5 | Wait cycles for the presented access, one cycle later |
| burst_cycles | output | BURST_W+6 | Total burst cost, one cycle later |

## Verification
A wrong entry in the latency table shows up only when a lookup selects that region with the matching width and sequential flag. It then appears at `wait_cycles` one cycle after the lookup. It also appears at `burst_cycles` in the same cycle, because the burst reuses both 32-bit values. A stale or misrouted prefetch flag shows only on ROM fetch lookups, as a zero where a data value was expected or the reverse. A field decoded from the wrong bit positions stays hidden until a word that differs in exactly those bits is written and that region is read in the next cycle.

// File: rtl/cwu_pkg.sv
`timescale 1ns/1ps
package cwu_pkg;
  localparam int LAT_W   = 5;
  localparam int NUM_ROM = 3;
  localparam logic [2:0] RG_SRAM = 3'd3;
  localparam logic [2:0] RG_XRAM = 3'd4;

  typedef struct packed {
    logic [LAT_W-1:0] n16;
    logic [LAT_W-1:0] s16;
    logic [LAT_W-1:0] n32;
    logic [LAT_W-1:0] s32;
  } lat_t;

  function automatic logic [LAT_W-1:0] first_wait(input logic [1:0] code);
    case (code)
      2'd0:    return LAT_W'(4);
      2'd1:    return LAT_W'(3);
      2'd2:    return LAT_W'(2);
      default: return LAT_W'(8);
    endcase
  endfunction

  function automatic logic [LAT_W-1:0] seq_wait(input int r, input logic short_sel);
    return short_sel ? LAT_W'(1) : LAT_W'(2 << r);
  endfunction

  function automatic lat_t rom_lat(input logic [1:0] code, input int r, input logic b);
    lat_t l;
    l.n16 = first_wait(code);
    l.s16 = seq_wait(r, b);
    l.n32 = l.n16 + l.s16 + LAT_W'(1);
    l.s32 = (l.s16 << 1) + LAT_W'(1);
    return l;
  endfunction

  function automatic lat_t sram_lat(input logic [1:0] code);
    lat_t l;
    l.n16 = first_wait(code);
    l.s16 = l.n16;
    l.n32 = (l.n16 << 1) + LAT_W'(1);
    l.s32 = l.n32;
    return l;
  endfunction

  function automatic lat_t rom_reset(input int r);
    lat_t l;
    l = '0;
    if (r < 2) begin
      l.n16 = LAT_W'(4);
      l.s16 = LAT_W'(2);
      l.n32 = LAT_W'(7);
      l.s32 = LAT_W'(5);
    end
    return l;
  endfunction

  function automatic lat_t xram_lat();
    lat_t l;
    l.n16 = LAT_W'(2);
    l.s16 = LAT_W'(2);
    l.n32 = LAT_W'(5);
    l.s32 = LAT_W'(5);
    return l;
  endfunction
endpackage

// File: rtl/cwu_decode.sv
`timescale 1ns/1ps
module cwu_decode
  import cwu_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int PF_BIT = 14
) (
  input  logic [CFG_W-1:0] word,
  output lat_t             rom_o [NUM_ROM],
  output lat_t             sram_o,
  output logic             pf_o
);
  for (genvar r = 0; r < NUM_ROM; r++) begin : g_rom
    localparam int FLD_HI = 3 * r + 3;
    localparam int SEQ_B  = 3 * r + 4;
    assign rom_o[r] = rom_lat(word[FLD_HI -: 2], r, word[SEQ_B]);
  end

  assign sram_o = sram_lat(word[1:0]);
  assign pf_o   = word[PF_BIT];
endmodule

// File: rtl/cwu_bank.sv
`timescale 1ns/1ps
module cwu_bank
  import cwu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  lat_t rom_d [NUM_ROM],
  input  lat_t sram_d,
  input  logic pf_d,
  output lat_t rom_q [NUM_ROM],
  output lat_t sram_q,
  output logic pf_q
);
  for (genvar r = 0; r < NUM_ROM; r++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)     rom_q[r] <= rom_reset(r);
      else if (we) rom_q[r] <= rom_d[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_q <= '0;
      pf_q   <= 1'b0;
    end else if (we) begin
      sram_q <= sram_d;
      pf_q   <= pf_d;
    end
  end
endmodule

// File: rtl/cwu_lookup.sv
`timescale 1ns/1ps
module cwu_lookup
  import cwu_pkg::*;
#(
  parameter int BURST_W = 8,
  localparam int COST_W = LAT_W + 1 + BURST_W
) (
  input  logic               clk,
  input  logic               rst,
  input  lat_t               rom_q [NUM_ROM],
  input  lat_t               sram_q,
  input  logic               pf_q,
  input  logic [2:0]         region,
  input  logic               wide,
  input  logic               seq,
  input  logic               fetch,
  input  logic [BURST_W-1:0] len,
  output logic [LAT_W-1:0]   wait_o,
  output logic [COST_W-1:0]  burst_o
);
  lat_t               sel;
  logic               is_rom;
  logic [LAT_W-1:0]   wait_n;
  logic [COST_W-1:0]  burst_n;

  always_comb begin
    sel    = '0;
    is_rom = 1'b0;
    for (int r = 0; r < NUM_ROM; r++) begin
      if (region == 3'(r)) begin
        sel    = rom_q[r];
        is_rom = 1'b1;
      end
    end
    if (region == RG_SRAM) sel = sram_q;
    if (region == RG_XRAM) sel = xram_lat();
  end

  always_comb begin
    if (wide) wait_n = seq ? sel.s32 : sel.n32;
    else      wait_n = seq ? sel.s16 : sel.n16;
    if (fetch && pf_q && is_rom) wait_n = '0;
  end

  always_comb begin
    if (len == '0) begin
      burst_n = '0;
    end else begin
      burst_n = COST_W'(sel.n32) + COST_W'(1)
              + COST_W'(len - BURST_W'(1)) * (COST_W'(sel.s32) + COST_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_o  <= '0;
      burst_o <= '0;
    end else begin
      wait_o  <= wait_n;
      burst_o <= burst_n;
    end
  end
endmodule

// File: rtl/cart_wait_unit.sv
`timescale 1ns/1ps
module cart_wait_unit
  import cwu_pkg::*;
#(
  parameter int CFG_W   = 16,
  parameter int BURST_W = 8,
  localparam int COST_W = LAT_W + 1 + BURST_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_data,
  input  logic [2:0]         lk_region,
  input  logic               lk_wide,
  input  logic               lk_seq,
  input  logic               lk_fetch,
  input  logic [BURST_W-1:0] burst_len,
  output logic [LAT_W-1:0]   wait_cycles,
  output logic [COST_W-1:0]  burst_cycles
);
  lat_t dec_rom [NUM_ROM];
  lat_t dec_sram;
  logic dec_pf;
  lat_t tab_rom [NUM_ROM];
  lat_t tab_sram;
  logic tab_pf;

  cwu_decode #(.CFG_W(CFG_W)) i_decode (
    .word   (cfg_data),
    .rom_o  (dec_rom),
    .sram_o (dec_sram),
    .pf_o   (dec_pf)
  );

  cwu_bank i_bank (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .rom_d  (dec_rom),
    .sram_d (dec_sram),
    .pf_d   (dec_pf),
    .rom_q  (tab_rom),
    .sram_q (tab_sram),
    .pf_q   (tab_pf)
  );

  cwu_lookup #(.BURST_W(BURST_W)) i_lookup (
    .clk     (clk),
    .rst     (rst),
    .rom_q   (tab_rom),
    .sram_q  (tab_sram),
    .pf_q    (tab_pf),
    .region  (lk_region),
    .wide    (lk_wide),
    .seq     (lk_seq),
    .fetch   (lk_fetch),
    .len     (burst_len),
    .wait_o  (wait_cycles),
    .burst_o (burst_cycles)
  );
endmodule

// File: rtl/cwu_checker.sv
`timescale 1ns/1ps
module cwu_checker #(
  parameter int CFG_W   = 16,
  parameter int BURST_W = 8,
  localparam int COST_W = 5 + 1 + BURST_W
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_we,
  input logic [CFG_W-1:0]   cfg_data,
  input logic [2:0]         lk_region,
  input logic               lk_wide,
  input logic               lk_seq,
  input logic               lk_fetch,
  input logic [BURST_W-1:0] burst_len,
  input logic [4:0]         wait_cycles,
  input logic [COST_W-1:0]  burst_cycles
);
  logic pf_shadow;
  always_ff @(posedge clk) begin
    if (rst)         pf_shadow <= 1'b0;
    else if (cfg_we) pf_shadow <= cfg_data[14];
  end

  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> (wait_cycles == '0 && burst_cycles == '0));

  assert_xram_fixed_R1: assert property (@(posedge clk) disable iff (rst)
    (lk_region == 3'd4) |=> (wait_cycles == ($past(lk_wide) ? 5'd5 : 5'd2)));

  assert_wait_max_R2: assert property (@(posedge clk) disable iff (rst)
    wait_cycles <= 5'd17);

  assert_fetch_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (pf_shadow && lk_fetch && lk_region < 3'd3) |=> (wait_cycles == '0));

  assert_burst_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (burst_len == '0) |=> (burst_cycles == '0));

  assert_burst_single_R7: assert property (@(posedge clk) disable iff (rst)
    (burst_len == BURST_W'(1) && lk_wide && !lk_seq && !lk_fetch)
      |=> (burst_cycles == COST_W'(wait_cycles) + COST_W'(1)));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    (lk_region > 3'd4) |=> (wait_cycles == '0 &&
                            burst_cycles == COST_W'($past(burst_len))));
endmodule

bind cart_wait_unit cwu_checker #(.CFG_W(CFG_W), .BURST_W(BURST_W)) i_cwu_checker (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .cfg_data     (cfg_data),
  .lk_region    (lk_region),
  .lk_wide      (lk_wide),
  .lk_seq       (lk_seq),
  .lk_fetch     (lk_fetch),
  .burst_len    (burst_len),
  .wait_cycles  (wait_cycles),
  .burst_cycles (burst_cycles)
);

// File: tb/test_cart_wait_unit.sv
`timescale 1ns/1ps
module test_cart_wait_unit;
  localparam int BURST_W = 8;
  localparam int COST_W  = 5 + 1 + BURST_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_we = 1'b0;
  logic [15:0]        cfg_data = '0;
  logic [2:0]         lk_region = '0;
  logic               lk_wide = 1'b0;
  logic               lk_seq = 1'b0;
  logic               lk_fetch = 1'b0;
  logic [BURST_W-1:0] burst_len = '0;
  logic [4:0]         wait_cycles;
  logic [COST_W-1:0]  burst_cycles;

  int n_cmp = 0;
  int n_bad = 0;
  logic       m_valid = 1'b0;
  logic [15:0] m_word = '0;

  always #2.5 clk = ~clk;

  cart_wait_unit #(.CFG_W(16), .BURST_W(BURST_W)) i_cart_wait_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .lk_region(lk_region), .lk_wide(lk_wide), .lk_seq(lk_seq),
    .lk_fetch(lk_fetch), .burst_len(burst_len),
    .wait_cycles(wait_cycles), .burst_cycles(burst_cycles)
  );

  function automatic int first_of(input logic [1:0] c);
    case (c)
      2'd0: return 4;
      2'd1: return 3;
      2'd2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic void lat_of(input int rg, output int n16, output int s16,
                                 output int n32, output int s32);
    n16 = 0; s16 = 0; n32 = 0; s32 = 0;
    if (rg < 3) begin
      if (!m_valid) begin
        if (rg < 2) begin n16 = 4; s16 = 2; n32 = 7; s32 = 5; end
      end else begin
        n16 = first_of(m_word[3*rg+3 -: 2]);
        s16 = m_word[3*rg+4] ? 1 : (rg == 0 ? 2 : (rg == 1 ? 4 : 8));
        n32 = n16 + 1 + s16;
        s32 = 2 * s16 + 1;
      end
    end else if (rg == 3) begin
      if (m_valid) begin
        n16 = first_of(m_word[1:0]); s16 = n16;
        n32 = 2 * n16 + 1; s32 = n32;
      end
    end else if (rg == 4) begin
      n16 = 2; s16 = 2; n32 = 5; s32 = 5;
    end
  endfunction

  function automatic int exp_wait(input int rg, input logic w, input logic s, input logic f);
    int a, b, c, d;
    lat_of(rg, a, b, c, d);
    if (f && m_valid && m_word[14] && rg < 3) return 0;
    if (w) return s ? d : c;
    return s ? b : a;
  endfunction

  function automatic int exp_burst(input int rg, input int len);
    int a, b, c, d;
    lat_of(rg, a, b, c, d);
    if (len == 0) return 0;
    return (1 + c) + (len - 1) * (1 + d);
  endfunction

  task automatic write_cfg(input logic [15:0] w);
    cfg_we = 1'b1; cfg_data = w;
    @(posedge clk);
    m_valid = 1'b1; m_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input int rg, input logic w, input logic s, input logic f,
                      input int len, input string tag);
    int ew, eb;
    lk_region = 3'(rg); lk_wide = w; lk_seq = s; lk_fetch = f;
    burst_len = BURST_W'(len);
    ew = exp_wait(rg, w, s, f);
    eb = exp_burst(rg, len);
    @(posedge clk);
    #1;
    n_cmp++;
    if (int'(wait_cycles) != ew) begin
      n_bad++;
      $display("FAIL %s wait rg=%0d w=%0d s=%0d f=%0d: got %0d expected %0d",
               tag, rg, w, s, f, wait_cycles, ew);
    end
    n_cmp++;
    if (int'(burst_cycles) != eb) begin
      n_bad++;
      $display("FAIL %s burst rg=%0d len=%0d: got %0d expected %0d",
               tag, rg, len, burst_cycles, eb);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    lk_region = 3'd1; lk_wide = 1'b1; burst_len = 8'd5;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (wait_cycles != 0 || burst_cycles != 0) begin
      n_bad++;
      $display("FAIL R1 in-reset outputs: got %0d/%0d expected 0/0", wait_cycles, burst_cycles);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 reset defaults, R9 unmapped regions
    for (int rg = 0; rg < 8; rg++)
      for (int k = 0; k < 4; k++)
        look(rg, k[1], k[0], 1'b0, 3, rg < 5 ? "R1" : "R9");

    // R2 non-sequential field per ROM window
    for (int rg = 0; rg < 3; rg++)
      for (int c = 0; c < 4; c++) begin
        write_cfg(16'(c) << (3 * rg + 2));
        look(rg, 1'b0, 1'b0, 1'b0, 1, "R2");
      end

    // R3 sequential bit; R4 derived 32-bit values
    for (int rg = 0; rg < 3; rg++)
      for (int b = 0; b < 2; b++) begin
        write_cfg((16'(b) << (3 * rg + 4)) | (16'd3 << (3 * rg + 2)));
        look(rg, 1'b0, 1'b1, 1'b0, 2, "R3");
        look(rg, 1'b1, 1'b1, 1'b0, 2, "R4");
        look(rg, 1'b1, 1'b0, 1'b0, 2, "R4");
      end

    // R5 SRAM table
    for (int c = 0; c < 4; c++) begin
      write_cfg(16'(c));
      for (int k = 0; k < 4; k++) look(3, k[1], k[0], 1'b0, 2, "R5");
    end

    // R6 prefetch override
    write_cfg(16'h4000 | 16'h0395);
    for (int rg = 0; rg < 5; rg++) begin
      look(rg, 1'b0, 1'b0, 1'b1, 2, "R6");
      look(rg, 1'b1, 1'b1, 1'b1, 2, "R6");
      look(rg, 1'b1, 1'b0, 1'b0, 2, "R6");
    end
    write_cfg(16'h0395);
    for (int rg = 0; rg < 3; rg++) look(rg, 1'b0, 1'b0, 1'b1, 1, "R6");

    // R7 burst lengths including 0 and maximum; fetch does not affect bursts
    write_cfg(16'h0300);
    look(2, 1'b1, 1'b0, 1'b0, 0, "R7");
    look(2, 1'b1, 1'b0, 1'b0, 1, "R7");
    look(2, 1'b1, 1'b0, 1'b0, 2, "R7");
    look(2, 1'b1, 1'b0, 1'b0, 255, "R7");
    write_cfg(16'h4300);
    look(2, 1'b1, 1'b0, 1'b1, 7, "R7");

    // R8 back-to-back writes, lookup in the next cycle
    cfg_we = 1'b1; cfg_data = 16'h000C;
    @(posedge clk); @(negedge clk);
    cfg_data = 16'h0008;
    @(posedge clk); m_valid = 1'b1; m_word = 16'h0008;
    @(negedge clk); cfg_we = 1'b0;
    look(0, 1'b0, 1'b0, 1'b0, 1, "R8");
    write_cfg(16'h0004);
    look(0, 1'b1, 1'b0, 1'b0, 4, "R8");

    // R9 unused control bits have no effect
    write_cfg(16'hB800 | 16'h0256);
    for (int rg = 0; rg < 8; rg++) look(rg, 1'b1, 1'b0, 1'b0, 3, "R9");

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0) write_cfg(16'($urandom));
      else look(int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
                1'($urandom), int'($urandom_range(0, 255)), "R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule